// File: doc/BRIEF.md
# Multithreaded Stage Skid-Buffer Controller

This block is the flow-control core of one in-order pipeline stage. It sits between an instruction supplier upstream and a consumer downstream, and it runs several hardware threads through the same stage. Every cycle a bundle of up to `IN_W` lanes arrives. Each lane carries a thread number, an opaque payload and a kill marker. The block forwards up to `OUT_W` payloads downstream in the same cycle. For each thread it keeps a five-state controller (idle, running, blocked, unblocking, squashing) and a private skid buffer.

Three downstream stages send per-thread block and unblock pulses. The retire stage sends a per-thread squash request and a squash-in-progress level. When a thread cannot move forward, its arrivals are parked in its skid buffer and a block pulse goes upstream. The unblock pulse goes upstream only once the parked work has drained. Each skid buffer holds `UP_LAT*IN_W + OUT_W` entries. That is enough for the lanes still in flight from an upstream that reacts to a block pulse with `UP_LAT` cycles of delay.

Top module: `stage_skid_ctl`

## Requirements
- R1: After reset every thread is idle, all stall flags are clear, and no output lane, upstream pulse or overflow flag is active.
- R2: Stall flag bit `s*NTHR+t` of `dn_blk` sets the flag for downstream stage s and thread t, and the same bit of `dn_ublk` clears it. If both arrive in one cycle, the clear wins. The new value takes effect in the same cycle. A thread is stalled while any of its three flags is set.
- R3: A stalled thread parks all its arriving lanes in its skid buffer and forwards nothing. It raises `up_block[t]` for one cycle, and only in the cycle it enters the blocked state.
- R4: A running or idle thread forwards its lanes in arrival order. Output lanes fill from lane 0 upward, and threads are served in ascending thread number. Lanes that find no free output slot go to the skid buffer, and the thread blocks with an `up_block` pulse.
- R5: An input lane with `in_kill` set is dropped and uses no output slot.
- R6: When a blocked thread's stalls clear, it becomes unblocking. It forwards parked entries oldest first, ahead of new arrivals, and appends new arrivals behind them. In the cycle its buffer becomes empty, it pulses `up_unblock[t]` and returns to running.
- R7: A squash request discards the thread's arrivals and its skid buffer contents, and the thread enters squashing. If the thread was blocked or unblocking, the block pulses `up_unblock[t]`. Nothing is forwarded for the thread in that cycle.
- R8: Checks run in this priority order: squash request, then squash-in-progress, then stall. Squash-in-progress also discards the thread's arrivals and buffer. A squashing thread returns to running, and forwards, in the first cycle with neither squash signal and no stall.
- R9: For each thread, every accepted lane that is not discarded by R7 or R8 leaves exactly once, in arrival order.
- R10: `skid_ovf` rises only when a push would exceed the capacity `UP_LAT*IN_W+OUT_W`. This never happens if upstream sends nothing to a thread from `UP_LAT` cycles after a block pulse until the following unblock pulse.
- R11: `up_block[t]` and `up_unblock[t]` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | IN_W | Lane valid |
| in_kill | input | IN_W | Lane already cancelled upstream |
| in_tid | input | IN_W*TW | Thread number per lane |
| in_data | input | IN_W*DW | Payload per lane |
| dn_blk | input | 3*NTHR | Block pulse, bit s*NTHR+t |
| dn_ublk | input | 3*NTHR | Unblock pulse, bit s*NTHR+t |
| rt_squash | input | NTHR | Squash request per thread |
| rt_busy | input | NTHR | Squash still in progress per thread |
| up_block | output | NTHR | Block pulse to upstream |
| up_unblock | output | NTHR | Unblock pulse to upstream |
| out_vld | output | OUT_W | Output lane valid |
| out_tid | output | OUT_W*TW | Thread number per output lane |
| out_data | output | OUT_W*DW | Payload per output lane |
| skid_ovf | output | 1 | Skid buffer push rejected |

## Verification
A wrong controller state shows at the ports within the same cycle. It appears as a missing, duplicated or misplaced upstream pulse, or as output lanes appearing for a thread that should be held or flushed. A corrupted skid pointer or count shows up later, on the first drain after a block: the payloads come out reordered, repeated or missing, and the per-thread scoreboard catches this at the next output. An error in the stall-flag bookkeeping shows up one cycle after the pulse that should have set or cleared the flag.

// File: rtl/skidctl_pkg.sv
package skidctl_pkg;
    localparam int NUM_DN = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLK   = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQ    = 3'd4
    } thr_state_e;
endpackage

// File: rtl/skidctl_stall_flags.sv
module skidctl_stall_flags #(
    parameter int NTHR = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [skidctl_pkg::NUM_DN*NTHR-1:0]   set_p,
    input  logic [skidctl_pkg::NUM_DN*NTHR-1:0]   clr_p,
    output logic [NTHR-1:0]                       stalled
);
    localparam int NB = skidctl_pkg::NUM_DN * NTHR;

    logic [NB-1:0] flag_d, flag_q;

    always_comb begin
        flag_d = (flag_q | set_p) & ~clr_p;
        for (int t = 0; t < NTHR; t++) begin
            stalled[t] = 1'b0;
            for (int s = 0; s < skidctl_pkg::NUM_DN; s++) begin
                stalled[t] = stalled[t] | flag_d[s*NTHR + t];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar i = 0; i < NB; i++) begin : g_chk
        // R2
        flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(set_p[i]));
        // R2
        clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr_p[i] |=> !flag_q[i]);
    end
endmodule

// File: rtl/skidctl_lane_gather.sv
module skidctl_lane_gather #(
    parameter int IN_W   = 3,
    parameter int TW     = 1,
    parameter int DW     = 16,
    parameter int THR_ID = 0,
    parameter int NW     = 2
) (
    input  logic [IN_W-1:0]          in_vld,
    input  logic [IN_W-1:0]          in_kill,
    input  logic [IN_W*TW-1:0]       in_tid,
    input  logic [IN_W*DW-1:0]       in_data,
    output logic [NW-1:0]            pend_cnt,
    output logic [IN_W-1:0][DW-1:0]  pend_data
);
    always_comb begin
        int n;
        n = 0;
        pend_data = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (in_vld[i] && !in_kill[i] && (in_tid[i*TW +: TW] == TW'(THR_ID))) begin
                pend_data[n] = in_data[i*DW +: DW];
                n = n + 1;
            end
        end
        pend_cnt = NW'(n);
    end
endmodule

// File: rtl/stage_skid_ctl.sv
module stage_skid_ctl #(
    parameter int NTHR   = 2,
    parameter int IN_W   = 3,
    parameter int OUT_W  = 2,
    parameter int UP_LAT = 2,
    parameter int DW     = 16
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [IN_W-1:0]                      in_vld,
    input  logic [IN_W-1:0]                      in_kill,
    input  logic [IN_W*((NTHR>1)?$clog2(NTHR):1)-1:0]  in_tid,
    input  logic [IN_W*DW-1:0]                   in_data,
    input  logic [skidctl_pkg::NUM_DN*NTHR-1:0]  dn_blk,
    input  logic [skidctl_pkg::NUM_DN*NTHR-1:0]  dn_ublk,
    input  logic [NTHR-1:0]                      rt_squash,
    input  logic [NTHR-1:0]                      rt_busy,
    output logic [NTHR-1:0]                      up_block,
    output logic [NTHR-1:0]                      up_unblock,
    output logic [OUT_W-1:0]                     out_vld,
    output logic [OUT_W*((NTHR>1)?$clog2(NTHR):1)-1:0] out_tid,
    output logic [OUT_W*DW-1:0]                  out_data,
    output logic                                 skid_ovf
);
    import skidctl_pkg::*;

    localparam int TW    = (NTHR > 1) ? $clog2(NTHR) : 1;
    localparam int DEPTH = UP_LAT * IN_W + OUT_W;
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NW    = $clog2(IN_W + 1);

    typedef struct packed {
        thr_state_e                 st;
        logic [PW-1:0]              head;
        logic [CW-1:0]              cnt;
        logic [DEPTH-1:0][DW-1:0]   mem;
    } thr_t;

    thr_t thr_d [NTHR];
    thr_t thr_q [NTHR];

    logic [NTHR-1:0]            stalled;
    logic [NW-1:0]              pend_cnt  [NTHR];
    logic [IN_W-1:0][DW-1:0]    pend_data [NTHR];

    skidctl_stall_flags #(.NTHR(NTHR)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_p   (dn_blk),
        .clr_p   (dn_ublk),
        .stalled (stalled)
    );

    for (genvar g = 0; g < NTHR; g++) begin : g_gather
        skidctl_lane_gather #(
            .IN_W(IN_W), .TW(TW), .DW(DW), .THR_ID(g), .NW(NW)
        ) u_gather (
            .in_vld    (in_vld),
            .in_kill   (in_kill),
            .in_tid    (in_tid),
            .in_data   (in_data),
            .pend_cnt  (pend_cnt[g]),
            .pend_data (pend_data[g])
        );
    end

    function automatic int wrap_idx(input int v);
        return (v >= DEPTH) ? v - DEPTH : v;
    endfunction

    always_comb begin
        int         slot;
        int         cnt;
        int         hd;
        logic       left;
        logic       sent;
        thr_state_e s;
        slot       = 0;
        up_block   = '0;
        up_unblock = '0;
        out_vld    = '0;
        out_tid    = '0;
        out_data   = '0;
        skid_ovf   = 1'b0;
        for (int t = 0; t < NTHR; t++) begin
            thr_d[t] = thr_q[t];
            s    = thr_q[t].st;
            cnt  = int'(thr_q[t].cnt);
            hd   = int'(thr_q[t].head);
            left = 1'b0;
            sent = 1'b0;
            if (rt_squash[t]) begin
                if (s == ST_BLK || s == ST_UNBLK) up_unblock[t] = 1'b1;
                s   = ST_SQ;
                cnt = 0;
                hd  = 0;
            end else if (rt_busy[t]) begin
                s   = ST_SQ;
                cnt = 0;
                hd  = 0;
            end else if (stalled[t]) begin
                for (int i = 0; i < IN_W; i++) begin
                    if (i < int'(pend_cnt[t])) begin
                        if (cnt < DEPTH) begin
                            thr_d[t].mem[wrap_idx(hd + cnt)] = pend_data[t][i];
                            cnt = cnt + 1;
                        end else begin
                            skid_ovf = 1'b1;
                        end
                    end
                end
                if (s != ST_BLK) up_block[t] = 1'b1;
                s = ST_BLK;
            end else begin
                if (s == ST_BLK)     s = ST_UNBLK;
                else if (s == ST_SQ) s = ST_RUN;
                if (s == ST_UNBLK) begin
                    for (int k = 0; k < OUT_W; k++) begin
                        if (cnt > 0 && slot < OUT_W) begin
                            out_vld[slot]           = 1'b1;
                            out_tid[slot*TW +: TW]  = TW'(t);
                            out_data[slot*DW +: DW] = thr_q[t].mem[hd];
                            hd   = wrap_idx(hd + 1);
                            cnt  = cnt - 1;
                            slot = slot + 1;
                        end
                    end
                    for (int i = 0; i < IN_W; i++) begin
                        if (i < int'(pend_cnt[t])) begin
                            if (cnt < DEPTH) begin
                                thr_d[t].mem[wrap_idx(hd + cnt)] = pend_data[t][i];
                                cnt = cnt + 1;
                            end else begin
                                skid_ovf = 1'b1;
                            end
                        end
                    end
                    if (cnt == 0) begin
                        up_unblock[t] = 1'b1;
                        s = ST_RUN;
                    end
                end else begin
                    for (int i = 0; i < IN_W; i++) begin
                        if (i < int'(pend_cnt[t])) begin
                            if (slot < OUT_W) begin
                                out_vld[slot]           = 1'b1;
                                out_tid[slot*TW +: TW]  = TW'(t);
                                out_data[slot*DW +: DW] = pend_data[t][i];
                                slot = slot + 1;
                                sent = 1'b1;
                            end else begin
                                left = 1'b1;
                                if (cnt < DEPTH) begin
                                    thr_d[t].mem[wrap_idx(hd + cnt)] = pend_data[t][i];
                                    cnt = cnt + 1;
                                end else begin
                                    skid_ovf = 1'b1;
                                end
                            end
                        end
                    end
                    if (left) begin
                        up_block[t] = 1'b1;
                        s = ST_BLK;
                    end else if (sent) begin
                        s = ST_RUN;
                    end
                end
            end
            thr_d[t].st   = s;
            thr_d[t].cnt  = CW'(cnt);
            thr_d[t].head = PW'(hd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTHR; t++) thr_q[t] <= '0;
        end else begin
            for (int t = 0; t < NTHR; t++) thr_q[t] <= thr_d[t];
        end
    end

    for (genvar t = 0; t < NTHR; t++) begin : g_thr_chk
        // R11
        no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(up_block[t] && up_unblock[t]));
        // R3
        single_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            up_block[t] |=> !up_block[t]);
        // R6
        unblock_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            up_unblock[t] |=> (thr_q[t].st == ST_RUN || thr_q[t].st == ST_SQ));
        // R6
        empty_when_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_q[t].st == ST_RUN) |-> (thr_q[t].cnt == '0));
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_lane_chk
        if (i + 1 < OUT_W) begin : g_pack
            // R4
            lane_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
                out_vld[i+1] |-> out_vld[i]);
        end
        // R7
        no_flush_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[i] |-> !(rt_squash[out_tid[i*TW +: TW]] || rt_busy[out_tid[i*TW +: TW]]));
    end
endmodule

// File: tb/stage_skid_ctl_tb_top.sv
`timescale 1ns/1ps
module stage_skid_ctl_tb_top;
    localparam int NTHR = 2;
    localparam int IN_W = 3;
    localparam int OUT_W = 2;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IN_W-1:0]    in_vld, in_kill;
    logic [IN_W-1:0]    in_tid;
    logic [IN_W*DW-1:0] in_data;
    logic [5:0]         dn_blk, dn_ublk;
    logic [1:0]         rt_squash, rt_busy;
    logic [1:0]         up_block, up_unblock;
    logic [OUT_W-1:0]   out_vld;
    logic [OUT_W-1:0]   out_tid;
    logic [OUT_W*DW-1:0] out_data;
    logic               skid_ovf;

    int nchk = 0;
    int nfail = 0;
    logic [DW-1:0] expq [NTHR][$];
    logic [1:0] upflag = '0;
    logic [1:0] gate = '0;
    logic mon_on = 1'b0;

    always #5 clk = ~clk;

    stage_skid_ctl #(.NTHR(NTHR), .IN_W(IN_W), .OUT_W(OUT_W), .UP_LAT(2), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_kill(in_kill), .in_tid(in_tid),
        .in_data(in_data), .dn_blk(dn_blk), .dn_ublk(dn_ublk), .rt_squash(rt_squash),
        .rt_busy(rt_busy), .up_block(up_block), .up_unblock(up_unblock), .out_vld(out_vld),
        .out_tid(out_tid), .out_data(out_data), .skid_ovf(skid_ovf)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr_in();
        in_vld = '0; in_kill = '0; in_tid = '0; in_data = '0;
        dn_blk = '0; dn_ublk = '0; rt_squash = '0; rt_busy = '0;
    endtask

    task automatic nxt();
        @(posedge clk);
        #1;
        clr_in();
    endtask

    task automatic lane(input int i, input bit k, input int t, input int d);
        in_vld[i] = 1'b1;
        in_kill[i] = k;
        in_tid[i] = t[0];
        in_data[i*DW +: DW] = DW'(d);
    endtask

    // Monitor: scoreboard and upstream reaction model
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            for (int i = 0; i < IN_W; i++) begin
                if (in_vld[i] && !in_kill[i] && !(rt_squash[in_tid[i]] || rt_busy[in_tid[i]]))
                    expq[in_tid[i]].push_back(in_data[i*DW +: DW]);
            end
            for (int t = 0; t < NTHR; t++) begin
                if (rt_squash[t] || rt_busy[t]) expq[t].delete();
            end
            for (int j = 0; j < OUT_W; j++) begin
                if (out_vld[j]) begin
                    if (expq[out_tid[j]].size() == 0) begin
                        chk("R9 unexpected output", {48'd0, out_data[j*DW +: DW]}, 64'hFFFF_FFFF);
                    end else begin
                        chk("R9 order", {48'd0, out_data[j*DW +: DW]}, {48'd0, expq[out_tid[j]].pop_front()});
                    end
                end
            end
            // R10 and R11 at every cycle
            if (skid_ovf) chk("R10 overflow", 64'(skid_ovf), 64'd0);
            if ((up_block & up_unblock) != 2'b00) chk("R11 dual pulse", 64'(up_block & up_unblock), 64'd0);
            for (int t = 0; t < NTHR; t++) begin
                gate[t] = upflag[t];
                if (up_block[t]) upflag[t] = 1'b1;
                if (up_unblock[t]) upflag[t] = 1'b0;
            end
        end
    end

    initial begin
        #3000000;
        nfail++;
        $display("FAIL R9 watchdog expired actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [1:0] stf [3];
        int busy_left [NTHR];
        int seq;
        clr_in();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        mon_on = 1'b1;
        #2;
        // R1 reset state
        chk("R1 out_vld", 64'(out_vld), 64'd0);
        chk("R1 pulses", 64'({up_block, up_unblock}), 64'd0);
        chk("R1 ovf", 64'(skid_ovf), 64'd0);
        nxt();

        // R4: two lanes of thread 0 forwarded in order
        lane(0, 0, 0, 1); lane(1, 0, 0, 2); #2;
        chk("R4 vld", 64'(out_vld), 64'b11);
        chk("R4 data", 64'(out_data), 64'h0002_0001);
        nxt();

        // R5 killed lane dropped; R4 thread order
        lane(0, 1, 1, 3); lane(1, 0, 1, 4); lane(2, 0, 0, 5); #2;
        chk("R5 vld", 64'(out_vld), 64'b11);
        chk("R4 tid order", 64'(out_tid), 64'b10);
        chk("R5 data", 64'(out_data), 64'h0004_0005);
        nxt();

        // R4 leftover forces block; R6 drain then unblock
        lane(0, 0, 0, 6); lane(1, 0, 0, 7); lane(2, 0, 0, 8); #2;
        chk("R4 leftover data", 64'(out_data), 64'h0007_0006);
        chk("R4 leftover block", 64'(up_block), 64'b01);
        nxt(); #2;
        chk("R6 drain vld", 64'(out_vld), 64'b01);
        chk("R6 drain data", 64'(out_data[15:0]), 64'd8);
        chk("R6 unblock", 64'({up_block, up_unblock}), 64'b0001);
        nxt();

        // R2/R3 downstream stall on thread 1 (stage 1 -> bit 3)
        dn_blk[3] = 1'b1; lane(0, 0, 1, 9); lane(1, 0, 1, 10); #2;
        chk("R3 block pulse", 64'(up_block), 64'b10);
        chk("R3 held", 64'(out_vld), 64'd0);
        nxt();
        lane(0, 0, 1, 11); #2;
        chk("R3 single pulse", 64'(up_block), 64'd0);
        chk("R3 still held", 64'(out_vld), 64'd0);
        nxt();
        dn_ublk[5] = 1'b1; #2;
        chk("R2 other stage clear", 64'({out_vld, up_unblock}), 64'd0);
        nxt();
        dn_ublk[3] = 1'b1; #2;
        chk("R6 oldest first", 64'(out_data), 64'h000A_0009);
        chk("R6 no early unblock", 64'(up_unblock), 64'd0);
        nxt(); #2;
        chk("R6 last entry", 64'(out_data[15:0]), 64'd11);
        chk("R6 unblock pulse", 64'(up_unblock), 64'b10);
        nxt();

        // R7 squash a blocked thread 0
        dn_blk[0] = 1'b1; lane(0, 0, 0, 12); lane(1, 0, 0, 13); #2;
        chk("R3 block t0", 64'(up_block), 64'b01);
        nxt();
        rt_squash[0] = 1'b1; dn_ublk[0] = 1'b1; lane(0, 0, 0, 14); #2;
        chk("R7 unblock on squash", 64'(up_unblock), 64'b01);
        chk("R7 no output", 64'(out_vld), 64'd0);
        nxt();
        lane(0, 0, 0, 15); #2;
        chk("R8 resume data", 64'({out_vld, out_data[15:0]}), {46'd0, 2'b01, 16'd15});
        nxt();

        // R8 squash-in-progress beats stall
        rt_busy[1] = 1'b1; dn_blk[1] = 1'b1; lane(0, 0, 1, 16); #2;
        chk("R8 busy priority", 64'({up_block, out_vld}), 64'd0);
        nxt(); #2;
        chk("R8 stall after squash", 64'(up_block), 64'b10);
        nxt();
        dn_ublk[1] = 1'b1; #2;
        chk("R6 empty unblock", 64'(up_unblock), 64'b10);
        nxt();

        // R2 simultaneous set and clear: clear wins
        dn_blk[0] = 1'b1; dn_ublk[0] = 1'b1; lane(0, 0, 0, 17); #2;
        chk("R2 clear wins", 64'({up_block, out_vld, out_data[15:0]}), {44'd0, 2'b00, 2'b01, 16'd17});
        nxt();

        // Random phase with legal upstream (R9, R10)
        for (int s = 0; s < 3; s++) stf[s] = '0;
        for (int t = 0; t < NTHR; t++) busy_left[t] = 0;
        seq = 100;
        for (int c = 0; c < 4000; c++) begin
            for (int s = 0; s < 3; s++) begin
                for (int t = 0; t < NTHR; t++) begin
                    if ($urandom_range(0, 15) == 0) begin
                        if (stf[s][t]) dn_ublk[s*NTHR + t] = 1'b1;
                        else           dn_blk[s*NTHR + t] = 1'b1;
                        stf[s][t] = ~stf[s][t];
                    end
                end
            end
            for (int t = 0; t < NTHR; t++) begin
                if (busy_left[t] > 0) begin
                    rt_busy[t] = 1'b1;
                    busy_left[t]--;
                end else if ($urandom_range(0, 63) == 0) begin
                    rt_squash[t] = 1'b1;
                    busy_left[t] = $urandom_range(0, 2);
                end
            end
            for (int i = 0; i < IN_W; i++) begin
                int t;
                t = $urandom_range(0, 1);
                if ($urandom_range(0, 3) != 0 && !gate[t]) begin
                    lane(i, ($urandom_range(0, 7) == 0), t, seq);
                    seq = (seq + 1) % 65536;
                end
            end
            nxt();
        end

        // Drain: release stalls, stop input
        for (int s = 0; s < 3; s++)
            for (int t = 0; t < NTHR; t++)
                if (stf[s][t]) dn_ublk[s*NTHR + t] = 1'b1;
        nxt();
        repeat (40) nxt();
        // R9 nothing lost
        chk("R9 t0 drained", 64'(expq[0].size()), 64'd0);
        chk("R9 t1 drained", 64'(expq[1].size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule